// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a core that fetches fixed-length 32-bit instructions. Each cycle it receives the decoded control-transfer kind of the current instruction, the two source register values and the raw immediate/target field. It decides whether a transfer happens and produces the address of the next instruction. That address is either the sequential successor, a PC-relative branch target, a region-absolute jump target or a target read from a register. For call instructions it also asks the register file to write the return address into a fixed link register.

Branch conditions are deliberately simple. Two registers are compared only for equality or inequality, and a single register is compared against zero using only its sign bit and a zero detector, so no subtractor sits on the branch path. No delay slot exists: when the unit is stepped, the PC register takes the computed next PC on that same clock edge. If an indirect target is not word aligned, a misalignment flag is raised and the PC is held.

Top module: `bnpc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes the reset vector (parameter `RST_PC`); `link_we` and `taken` are 0 whenever `op` is 0.
- R2: Op code 0 (sequential) and the unused codes 11 to 15 give `next_pc` = `pc` + 4 and `taken` = 0.
- R3: Op 1 (branch if equal) is taken when `rs_val` == `rt_val`; op 2 (branch if not equal) is taken when they differ.
- R4: The zero tests read `rs_val` as signed: op 3 is taken when it is <= 0, op 4 when > 0, op 5 when < 0, op 6 when >= 0.
- R5: A taken conditional branch gives `next_pc` = `pc` + 4 + (sign-extended `imm_field[15:0]` times 4), modulo 2^32; a branch not taken gives `pc` + 4.
- R6: Ops 7 (jump) and 8 (jump and link) give `next_pc` = {bits 31:28 of `pc` + 4, `imm_field[25:0]`, 2'b00} and `taken` = 1.
- R7: Ops 9 (indirect jump) and 10 (indirect jump and link) with `rs_val[1:0]` == 0 give `next_pc` = `rs_val` and `taken` = 1.
- R8: Ops 8 and 10 (when not misaligned) drive `link_we` = 1, `link_idx` = 31 and `link_val` = `pc` + 4; all other ops drive `link_we` = 0.
- R9: Ops 9 and 10 with `rs_val[1:0]` != 0 drive `misalign` = 1, `taken` = 0, `link_we` = 0 and `next_pc` = `pc`, so a step leaves `pc` unchanged.
- R10: When `step` is 0, `pc` keeps its value at the clock edge whatever the other inputs are.
- R11: When `step` is 1, `pc` takes the value `next_pc` had before that same rising edge (no delay slot).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Retire the current instruction and advance the PC |
| op | input | 4 | Control-transfer kind of the current instruction |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm_field | input | 26 | Raw immediate / jump target field |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address the PC takes on the next step |
| taken | output | 1 | A control transfer redirects the PC |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Register written with the return address |
| link_val | output | 32 | Return address value |
| misalign | output | 1 | Indirect target not word aligned |

## Verification
The bench builds the unit with its default 32-bit width, 16-bit offset and 26-bit target field, but with a nonzero reset vector so the reset check cannot pass by chance. It steers the PC through indirect jumps to chosen addresses, including ones next to the top of the address space and next to a 256 MB region boundary. This brings the carry out of PC + 4, the upper-bit splice of absolute jumps and the wrap of negative offsets within reach. Every op code, including the unused ones, is crossed with operand values at zero, one, minus one and both signed extremes and with offsets at both signed extremes.

// File: rtl/bnpc_pkg.sv
// Package: shared op encoding for the branch and next-PC unit.
// Assumes a 4-bit op field produced by the instruction decoder.
package bnpc_pkg;

    typedef enum logic [3:0] {
        OP_SEQ   = 4'd0,
        OP_BEQ   = 4'd1,
        OP_BNE   = 4'd2,
        OP_BLEZ  = 4'd3,
        OP_BGTZ  = 4'd4,
        OP_BLTZ  = 4'd5,
        OP_BGEZ  = 4'd6,
        OP_JMP   = 4'd7,
        OP_JAL   = 4'd8,
        OP_JR    = 4'd9,
        OP_JALR  = 4'd10
    } bnpc_op_e;

endpackage

// File: rtl/bnpc_cond.sv
// Module: branch condition evaluator.
// Decides whether a conditional branch is taken. Uses only an equality
// comparator, a zero detector and the sign bit; no subtraction.
// Assumes op is one of the package codes; non-branch codes give 0.
module bnpc_cond
    import bnpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  bnpc_op_e          op,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic              is_branch,
    output logic              cond_true
);

    logic eq;
    logic zero;
    logic neg;

    // Shared comparison primitives.
    always_comb begin
        eq   = (rs_val == rt_val);
        zero = (rs_val == '0);
        neg  = rs_val[XLEN-1];
    end

    // Per-op condition selection.
    always_comb begin
        is_branch = 1'b1;
        cond_true = 1'b0;
        unique case (op)
            OP_BEQ:  cond_true = eq;
            OP_BNE:  cond_true = !eq;
            OP_BLEZ: cond_true = neg || zero;
            OP_BGTZ: cond_true = !neg && !zero;
            OP_BLTZ: cond_true = neg;
            OP_BGEZ: cond_true = !neg;
            default: is_branch = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_target.sv
// Module: candidate target generator.
// Forms the sequential, PC-relative and region-absolute addresses from
// the current PC and the raw immediate field. Assumes XLEN >= OFF_W + 2.
module bnpc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [TGT_W-1:0] imm_field,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_pc,
    output logic [XLEN-1:0]  jmp_pc
);

    localparam int INSN_BYTES = 4;
    localparam int EXT_W      = XLEN - OFF_W;
    localparam int REGION_W   = XLEN - TGT_W - 2;

    logic [XLEN-1:0] off_ext;

    // Sequential successor and sign-extended, word-scaled branch offset.
    always_comb begin
        seq_pc  = pc + XLEN'(INSN_BYTES);
        off_ext = {{EXT_W{imm_field[OFF_W-1]}}, imm_field[OFF_W-1:0]};
        br_pc   = seq_pc + (off_ext << 2);
    end

    // Absolute target: keep the PC region bits when the field is narrower.
    generate
        if (REGION_W > 0) begin : g_region
            always_comb jmp_pc = {seq_pc[XLEN-1 -: REGION_W], imm_field, 2'b00};
        end else begin : g_full
            logic [TGT_W+1:0] wide;
            always_comb begin
                wide   = {imm_field, 2'b00};
                jmp_pc = wide[XLEN-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/bnpc_top.sv
// Module: branch and next-PC unit.
// Holds the PC, picks the next PC among sequential, branch, absolute and
// register targets, and drives the return-address write for calls.
// Assumes a single-cycle redirect (no delay slot) and word-aligned code.
module bnpc_top
    import bnpc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              OFF_W    = 16,
    parameter int              TGT_W    = 26,
    parameter int              RIDX_W   = 5,
    parameter int              LINK_REG = 31,
    parameter logic [XLEN-1:0] RST_PC   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [3:0]        op,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    input  logic [TGT_W-1:0]  imm_field,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val,
    output logic              misalign
);

    bnpc_op_e        op_e;
    logic            is_branch;
    logic            cond_true;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;
    logic            is_abs;
    logic            is_ind;
    logic            is_call;

    // Decode the op field into transfer classes.
    always_comb begin
        op_e    = bnpc_op_e'(op);
        is_abs  = (op_e == OP_JMP) || (op_e == OP_JAL);
        is_ind  = (op_e == OP_JR)  || (op_e == OP_JALR);
        is_call = (op_e == OP_JAL) || (op_e == OP_JALR);
    end

    bnpc_cond #(.XLEN(XLEN)) u_cond (
        .op        (op_e),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .is_branch (is_branch),
        .cond_true (cond_true)
    );

    bnpc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
        .pc        (pc),
        .imm_field (imm_field),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc),
        .jmp_pc    (jmp_pc)
    );

    // Next-PC selection, misalignment detection and link request.
    always_comb begin
        misalign = is_ind && (rs_val[1:0] != 2'b00);
        taken    = 1'b0;
        next_pc  = seq_pc;
        if (misalign) begin
            next_pc = pc;
        end else if (is_ind) begin
            taken   = 1'b1;
            next_pc = rs_val;
        end else if (is_abs) begin
            taken   = 1'b1;
            next_pc = jmp_pc;
        end else if (is_branch && cond_true) begin
            taken   = 1'b1;
            next_pc = br_pc;
        end
        link_we  = is_call && !misalign;
        link_idx = RIDX_W'(LINK_REG);
        link_val = seq_pc;
    end

    // PC register: reset vector, then follow next_pc on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RST_PC;
        else if (step)
            pc <= next_pc;
    end

    // R11
    pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step) |-> pc == $past(next_pc));

    // R10
    pc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(step) |-> $stable(pc));

    // R9
    misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(misalign) |-> $stable(pc));

    // R7
    indirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && (op == 4'd9) && (rs_val[1:0] == 2'b00) |=> pc == $past(rs_val));

    // R8
    link_call_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> ((op == 4'd8) || (op == 4'd10)) && !misalign);

    // R9
    misalign_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> !link_we && !taken);

endmodule

// File: tb/tb_bnpc_top.sv
module tb_bnpc_top;

    localparam int          CLK_P  = 10;
    localparam logic [31:0] RST_PC = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step;
    logic [3:0]  op;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [25:0] imm_field;
    logic [31:0] pc;
    logic [31:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;
    logic        misalign;

    int checks = 0;
    int errors = 0;

    bnpc_top #(.RST_PC(RST_PC)) dut (
        .clk(clk), .rst_n(rst_n), .step(step), .op(op),
        .rs_val(rs_val), .rt_val(rt_val), .imm_field(imm_field),
        .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
        .link_idx(link_idx), .link_val(link_val), .misalign(misalign)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Steer the PC to an aligned address through an indirect jump.
    task automatic load_pc(input logic [31:0] v);
        @(negedge clk);
        op = 4'd9; rs_val = v; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk("R7 load", pc, v);
    endtask

    // Apply one op, check combinational outputs, then step and check pc.
    task automatic try_op(input logic [3:0] o, input logic [31:0] a,
                          input logic [31:0] b, input logic [25:0] f);
        logic [31:0] p, seq, ext, exp_n;
        logic        cnd, exp_t, exp_l, exp_m, rel;
        p = pc;
        seq = p + 32'd4;
        ext = {{16{f[15]}}, f[15:0]};
        rel = 1'b0; cnd = 1'b0;
        case (o)
            4'd1: begin rel = 1; cnd = (a == b); end
            4'd2: begin rel = 1; cnd = (a != b); end
            4'd3: begin rel = 1; cnd = ($signed(a) <= 0); end
            4'd4: begin rel = 1; cnd = ($signed(a) > 0); end
            4'd5: begin rel = 1; cnd = ($signed(a) < 0); end
            4'd6: begin rel = 1; cnd = ($signed(a) >= 0); end
            default: ;
        endcase
        exp_m = (o == 4'd9 || o == 4'd10) && (a[1:0] != 2'b00);
        exp_l = (o == 4'd8 || o == 4'd10) && !exp_m;
        exp_t = 1'b0; exp_n = seq;
        if (exp_m) exp_n = p;
        else if (o == 4'd9 || o == 4'd10) begin exp_t = 1; exp_n = a; end
        else if (o == 4'd7 || o == 4'd8) begin exp_t = 1; exp_n = {seq[31:28], f, 2'b00}; end
        else if (rel && cnd) begin exp_t = 1; exp_n = seq + ext * 32'd4; end
        op = o; rs_val = a; rt_val = b; imm_field = f; step = 1'b0;
        #1;
        if (rel) begin
            chk((o <= 4'd2) ? "R3 taken" : "R4 taken", {31'd0, taken}, {31'd0, exp_t});
            chk("R5 next_pc", next_pc, exp_n);
        end else if (o == 4'd7 || o == 4'd8) begin
            chk("R6 next_pc", next_pc, exp_n);
            chk("R6 taken", {31'd0, taken}, {31'd0, exp_t});
        end else if (o == 4'd9 || o == 4'd10) begin
            chk(exp_m ? "R9 next_pc" : "R7 next_pc", next_pc, exp_n);
            chk("R9 misalign", {31'd0, misalign}, {31'd0, exp_m});
        end else begin
            chk("R2 next_pc", next_pc, exp_n);
            chk("R2 taken", {31'd0, taken}, {31'd0, exp_t});
        end
        chk("R8 link_we", {31'd0, link_we}, {31'd0, exp_l});
        if (exp_l) begin
            chk("R8 link_idx", {27'd0, link_idx}, 32'd31);
            chk("R8 link_val", link_val, seq);
        end
        // R10: an idle edge leaves pc alone.
        @(negedge clk);
        chk("R10 idle hold", pc, p);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk(exp_m ? "R9 pc held" : "R11 pc update", pc, exp_n);
    endtask

    logic [31:0] pcs  [6] = '{32'h0000_1000, 32'hFFFF_FFF8, 32'h7FFF_FFF0,
                              32'h0FFF_FFFC, 32'h0000_0000, 32'h8000_0010};
    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h1234_5678};
    logic [25:0] offs [5] = '{26'h0, 26'h1, 26'h7FFF, 26'h8000, 26'h3FF_FFFF};

    initial begin : main
        rst_n = 1'b0; step = 1'b1; op = 4'd0;
        rs_val = '0; rt_val = '0; imm_field = '0;
        repeat (2) @(negedge clk);
        // R1: reset vector loaded even with step high.
        chk("R1 reset pc", pc, RST_PC);
        chk("R1 link_we", {31'd0, link_we}, 32'd0);
        chk("R1 taken", {31'd0, taken}, 32'd0);
        rst_n = 1'b1; step = 1'b0;
        for (int ip = 0; ip < 6; ip++) begin
            for (int o = 0; o < 16; o++) begin
                for (int ia = 0; ia < 6; ia++) begin
                    for (int io = 0; io < 5; io++) begin
                        load_pc(pcs[ip]);
                        try_op(4'(o), vals[ia], vals[(ia + io) % 6], offs[io]);
                    end
                end
            end
        end
        // R3: equal operands that are nonzero.
        load_pc(32'h0000_4000);
        try_op(4'd1, 32'hDEAD_BEEC, 32'hDEAD_BEEC, 26'h10);
        load_pc(32'h0000_4000);
        try_op(4'd2, 32'hDEAD_BEEC, 32'hDEAD_BEEC, 26'h10);
        // R9: each misaligned low-bit pattern for both indirect ops.
        for (int m = 1; m < 4; m++) begin
            load_pc(32'h0000_2000);
            try_op(4'd9, 32'h0000_3000 | 32'(m), 32'h0, 26'h0);
            load_pc(32'h0000_2000);
            try_op(4'd10, 32'h0000_3000 | 32'(m), 32'h0, 26'h0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule